// File: doc/BRIEF.md
# Encoded Audio Clock Divider

This block derives the three clocks of a serial stereo audio link from one module clock. It produces a master clock, a bit clock and a frame (left/right) clock. One 8-bit configuration word sets the ratios through small lookup codes, so the ratios are not binary divide counts. Bit 7 of the word enables the outputs. Bits [3:0] hold the master code, which selects a ratio of 1, 2, 4, 6, 8, 12, 16 or 24 module clocks. Bits [6:4] hold the bit-clock code, which selects 2, 4, 6, 8, 12 or 16 master periods per bit clock. The frame clock completes one period every two words of `WORD_BITS` bit clocks.

Software picks the codes from the oversample rate, which is 128, 192, 256, 384, 512 or 768 times the sample rate. The bit-clock ratio is that oversample rate divided by twice the word size, so 16-bit words at 256x give ratio 8. The module clock is 24.576 MHz for the 8 kHz and 12 kHz rate families and 22.5792 MHz for the 11.025 kHz family.

Codes are sampled only while the block is idle or at a rising frame-clock edge. A ratio change therefore never produces a shortened pulse. Illegal codes raise an error flag and silence every output.

Top module: `audio_clk_div`

## Requirements
- R1: After reset, `mclk_o`, `bclk_o`, `lrclk_o` and `code_err` are all low.
- R2: Master code c in bits [3:0] (c = 0..7 → 1, 2, 4, 6, 8, 12, 16, 24) makes `mclk_o` a square wave of that many module clocks, high and low for half each. Counting starts low, on the first module clock edge at which the block runs.
- R3: With master code 0 (ratio 1), `mclk_o` is the module clock itself while the block runs.
- R4: Bit-clock code k in bits [6:4] (k = 0..5 → 2, 4, 6, 8, 12, 16) gives `bclk_o` a period of that ratio times the master ratio in module clocks, with a 50% duty cycle. It starts low together with the master clock, so its edges fall on master clock edges.
- R5: `lrclk_o` starts low and changes only together with a falling `bclk_o`, once every `WORD_BITS` bit-clock periods. Its first rise comes `WORD_BITS` bit clocks after the start.
- R6: While bit 7 of `div_cfg` is low, all clock outputs are low one module clock later. Raising bit 7 again restarts every clock from its initial phase.
- R7: Master codes 8..15 or bit-clock codes 6 and 7 set `code_err` and hold all clock outputs low. A legal code clears the flag and restarts the clocks.
- R8: While running, a code change is ignored until the next rising edge of `lrclk_o`. At that edge the new codes load, the master and bit clocks restart low, and `lrclk_o` begins its high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | 8 | [7] enable, [6:4] bit-clock code, [3:0] master code |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |
| code_err | output | 1 | Active codes are illegal |

## Verification
The assertions assume that `div_cfg` is synchronous to the module clock and changes at most once per cycle, away from both clock edges. They also assume that reset is held long enough for the loaded codes to start from zero. The bench changes `div_cfg` only after the falling edge of each cycle. It lays every code change down mid-frame, so the hold-until-frame-edge rule is exercised rather than sidestepped. Ratio-1 runs are entered and left both from idle and across a frame edge, so the clock-pass-through select is seen switching in both directions.

// File: rtl/audio_clk_div.sv
module audio_clk_div #(
  parameter int WORD_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] div_cfg,
  output logic       mclk_o,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       code_err
);
  localparam int BW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(WORD_BITS - 1);

  function automatic logic [4:0] m_ratio(input logic [3:0] c);
    case (c)
      4'd0:    m_ratio = 5'd1;
      4'd1:    m_ratio = 5'd2;
      4'd2:    m_ratio = 5'd4;
      4'd3:    m_ratio = 5'd6;
      4'd4:    m_ratio = 5'd8;
      4'd5:    m_ratio = 5'd12;
      4'd6:    m_ratio = 5'd16;
      4'd7:    m_ratio = 5'd24;
      default: m_ratio = 5'd0;
    endcase
  endfunction

  function automatic logic [3:0] b_half(input logic [2:0] c);
    case (c)
      3'd0:    b_half = 4'd1;
      3'd1:    b_half = 4'd2;
      3'd2:    b_half = 4'd3;
      3'd3:    b_half = 4'd4;
      3'd4:    b_half = 4'd6;
      3'd5:    b_half = 4'd8;
      default: b_half = 4'd0;
    endcase
  endfunction

  logic [3:0]    act_m;
  logic [2:0]    act_b;
  logic [3:0]    mcnt;
  logic [8:0]    bcnt;
  logic [BW-1:0] bitcnt;
  logic          mclk_q, bclk_q, lr_q, m1_sel;

  wire       legal    = (act_m < 4'd8) && (act_b < 3'd6);
  wire       in_legal = (div_cfg[3:0] < 4'd8) && (div_cfg[6:4] < 3'd6);
  wire       run      = div_cfg[7] && legal;
  wire [4:0] mr       = m_ratio(act_m);
  wire [3:0] m_last   = mr[4:1] - 4'd1;
  wire [8:0] hb       = 9'(mr) * 9'(b_half(act_b));
  wire [8:0] hb_last  = hb - 9'd1;
  wire       bfall    = run && (bcnt == hb_last) && bclk_q;
  wire       f_rise   = bfall && (bitcnt == BIT_LAST) && !lr_q;
  wire       load     = !run || f_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_m  <= '0;
      act_b  <= '0;
      mcnt   <= '0;
      bcnt   <= '0;
      bitcnt <= '0;
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else begin
      if (load) begin
        act_m <= div_cfg[3:0];
        act_b <= div_cfg[6:4];
      end
      if (!run || f_rise) begin
        mcnt   <= '0;
        bcnt   <= '0;
        bitcnt <= '0;
        mclk_q <= 1'b0;
        bclk_q <= 1'b0;
        lr_q   <= run && in_legal;
      end else begin
        if (act_m == 4'd0) begin
          mclk_q <= 1'b0;
        end else if (mcnt == m_last) begin
          mcnt   <= '0;
          mclk_q <= ~mclk_q;
        end else begin
          mcnt <= mcnt + 4'd1;
        end
        if (bcnt == hb_last) begin
          bcnt   <= '0;
          bclk_q <= ~bclk_q;
          if (bclk_q) begin
            if (bitcnt == BIT_LAST) begin
              bitcnt <= '0;
              lr_q   <= ~lr_q;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end else begin
          bcnt <= bcnt + 9'd1;
        end
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) m1_sel <= 1'b0;
    else        m1_sel <= run && (act_m == 4'd0);
  end

  assign mclk_o   = m1_sel ? clk : mclk_q;
  assign bclk_o   = bclk_q;
  assign lrclk_o  = lr_q;
  assign code_err = !legal;

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !div_cfg[7] |=> (!mclk_q && !bclk_q && !lr_q));

  a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> (!mclk_q && !bclk_q && !lr_q));

  a_r5_lr_rise_on_bfall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lr_q) |-> $fell(bclk_q));

  a_r5_lr_fall_on_bfall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lr_q) && $past(run)) |-> $fell(bclk_q));

  a_r8_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$fell(bclk_q)) |-> ($stable(act_m) && $stable(act_b)));
endmodule

// File: tb/audio_clk_div_tb.sv
`timescale 1ns/1ps
module audio_clk_div_tb;
  localparam int W = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg = 8'd0;
  logic       mclk_o, bclk_o, lrclk_o, code_err;

  audio_clk_div #(.WORD_BITS(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_cfg(cfg),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .lrclk_o(lrclk_o), .code_err(code_err)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic  mh, ml, b, l, e;
    string tag;
  } exp_t;

  exp_t  q[$];
  exp_t  mon_e;
  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  int    am = 0, ab = 0, u = 0, p = 0;
  bit    sel_prev = 1'b0;

  function automatic int mrat(int c);
    case (c)
      0: return 1;  1: return 2;  2: return 4;  3: return 6;
      4: return 8;  5: return 12; 6: return 16; 7: return 24;
      default: return 0;
    endcase
  endfunction

  function automatic int brat(int c);
    case (c)
      0: return 2; 1: return 4; 2: return 6; 3: return 8;
      4: return 12; 5: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic bit lg(int m, int b);
    return (m < 8) && (b < 6);
  endfunction

  task automatic step();
    exp_t e;
    bit   en, run_b, zero, new_sel;
    int   mm, bb, ff, un, mq, bq, lq;
    @(posedge clk);
    #1;
    en    = cfg[7];
    run_b = en && lg(am, ab);
    zero  = 1'b0;
    if (!run_b) begin
      am = cfg[3:0]; ab = cfg[6:4]; u = 0; p = 0; zero = 1'b1;
    end else begin
      ff = W * mrat(am) * brat(ab);
      un = u + 1;
      if ((un % ff == 0) && (((un / ff) + p) % 2 == 1)) begin
        am = cfg[3:0]; ab = cfg[6:4]; u = 0; p = 1;
        zero = !lg(am, ab);
      end else begin
        u = un;
      end
    end
    if (zero) begin
      mq = 0; bq = 0; lq = 0;
    end else begin
      mm = mrat(am); bb = brat(ab);
      mq = (mm == 1) ? 0 : (u / (mm / 2)) % 2;
      bq = (u / (mm * bb / 2)) % 2;
      lq = ((u / (W * mm * bb)) + p) % 2;
    end
    new_sel = en && lg(am, ab) && (am == 0);
    e.mh  = sel_prev ? 1'b1 : mq[0];
    e.ml  = new_sel ? 1'b0 : mq[0];
    e.b   = bq[0];
    e.l   = lq[0];
    e.e   = !lg(am, ab);
    e.tag = tag;
    sel_prev = new_sel;
    q.push_back(e);
    #2;
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic start(int mc, int bc);
    cfg = {1'b0, 3'(bc), 4'(mc)};
    step();
    cfg[7] = 1'b1;
  endtask

  task automatic stop();
    tag = "R6";
    cfg[7] = 1'b0;
    run_n(3);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() != 0) begin
      mon_e = q.pop_front();
      n_cmp++;
      if ({mclk_o, bclk_o, lrclk_o, code_err} !== {mon_e.mh, mon_e.b, mon_e.l, mon_e.e}) begin
        n_bad++;
        $display("FAIL %s mclk/bclk/lrclk/err act=%b%b%b%b exp=%b%b%b%b at %0t", mon_e.tag,
                 mclk_o, bclk_o, lrclk_o, code_err, mon_e.mh, mon_e.b, mon_e.l, mon_e.e, $time);
      end
      #2;
      n_cmp++;
      if (mclk_o !== mon_e.ml) begin
        n_bad++;
        $display("FAIL %s mclk low phase act=%b exp=%b at %0t", mon_e.tag, mclk_o, mon_e.ml, $time);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if ({mclk_o, bclk_o, lrclk_o, code_err} !== 4'b0000) begin
      n_bad++;
      $display("FAIL R1 reset outputs act=%b%b%b%b exp=0000", mclk_o, bclk_o, lrclk_o, code_err);
    end
    #2 rst_n = 1'b1;
    run_n(2);

    for (int mc = 0; mc < 8; mc++) begin
      tag = (mc == 0) ? "R3 R5" : "R2 R5";
      start(mc, 3);
      run_n(2 * W * mrat(mc) * 8 + 5);
      stop();
    end

    for (int bc = 0; bc < 6; bc++) begin
      tag = "R4 R5";
      start(1, bc);
      run_n(2 * W * 2 * brat(bc) + 5);
      stop();
    end

    tag = "R8";
    start(1, 1);
    run_n(40);
    cfg[6:0] = {3'd2, 4'd3};
    run_n(128 + 2 * 576 + 10);
    cfg[6:0] = {3'd0, 4'd0};
    run_n(576 + 2 * 32 + 10);
    cfg[6:0] = {3'd3, 4'd2};
    run_n(32 + 2 * 512 + 10);
    stop();

    tag = "R7";
    cfg = {1'b0, 3'd6, 4'd1};
    run_n(2);
    cfg[7] = 1'b1;
    run_n(5);
    cfg[6:4] = 3'd1;
    run_n(300);
    cfg[3:0] = 4'd9;
    run_n(300);
    cfg = {1'b1, 3'd1, 4'd1};
    run_n(200);
    stop();

    run_n(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule